// File: doc/BRIEF.md
# Load-linked store-conditional monitor

This block holds the single reservation bit behind a load-linked / store-conditional instruction pair. A linked load arms the reservation and fetches one word from memory for the R0 result. A conditional store reports the reservation state as its success bit, then writes R0 to memory only if that bit is set. An interrupt or exception event drops the reservation. The reservation is one flag with no address compare, so any intervening trap makes the next conditional store fail.

The processor presents one operation at a time on strobe inputs while the block is idle. The block turns each operation into at most one memory request on a request/acknowledge port. It pulses a completion strobe when the operation is finished. For a linked load it also drives the loaded word. For a conditional store it drives the success bit that the core copies into its T flag.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the reservation is clear, `mem_req_o`, `busy_o`, `done_o` and `t_o` are 0, and a first conditional store reports `t_o` = 0 and issues no write.
- R2: A linked load accepted while idle sets the reservation and issues a read (`mem_we_o` = 0) of `ll_addr_i`. On acknowledge, `mem_rdata_i` appears on `r0_o` together with a one-cycle `done_o`.
- R3: A conditional store accepted while idle copies the reservation into `t_o` at acceptance. `t_o` holds that value until the next conditional store.
- R4: When the copied value is 1, the block issues exactly one write (`mem_we_o` = 1) of `sc_data_i` to `sc_addr_i` and raises `done_o` after the acknowledge. When the copied value is 0, it issues no memory request and raises `done_o` the cycle after acceptance.
- R5: Every conditional store clears the reservation, whether it succeeds or fails, so a second store with no linked load in between reports `t_o` = 0.
- R6: `evt_i` clears the reservation in any cycle, including while a linked load waits for its acknowledge. The load still completes with its data.
- R7: When `evt_i` arrives in the same cycle a linked load is accepted, the reservation ends at 0.
- R8: `mem_req_o` is high for one cycle per request. `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady until `mem_ack_i` is seen.
- R9: Strobes that arrive while `busy_o` is high are ignored. When both strobes arrive together while idle, the linked load is taken and the conditional store is dropped.
- R10: When `evt_i` arrives in the same cycle a conditional store is accepted, `t_o` takes the reservation value from before the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ll_req_i | input | 1 | Linked-load strobe |
| ll_addr_i | input | AW | Linked-load address |
| sc_req_i | input | 1 | Conditional-store strobe |
| sc_addr_i | input | AW | Conditional-store address |
| sc_data_i | input | DW | Conditional-store data (R0) |
| evt_i | input | 1 | Interrupt or exception taken |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory address, held until acknowledge |
| mem_wdata_o | output | DW | Write data, held until acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| busy_o | output | 1 | A memory access is outstanding |
| done_o | output | 1 | One-cycle operation complete |
| t_o | output | 1 | Success bit of the latest conditional store |
| r0_o | output | DW | Word returned by the latest linked load |

## Verification
The bench builds the block with its default 32-bit address and data widths. Random addresses and data therefore cover the full field, including the top bits of the held write fields. The memory model answers each request after a random 0 to 3 cycles, so an acknowledge can come in the request cycle itself or after a long hold. Events are placed at acceptance, one cycle after acceptance, and alone between operations. This reaches every ordering of trap and reservation that the flag can see.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/llsc_resv_flag.sv
module llsc_resv_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic consume_i,
  input  logic evt_i,
  output logic flag_o
);
  logic flag_q;

  // trap and store clear beat arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (evt_i || consume_i) flag_q <= 1'b0;
    else if (arm_i)              flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/llsc_mem_port.sv
module llsc_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          launch_we_i,
  input  logic [AW-1:0] launch_addr_i,
  input  logic [DW-1:0] launch_wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          req_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= launch_i;
      if (launch_i) begin
        we_q    <= launch_we_i;
        addr_q  <= launch_addr_i;
        wdata_q <= launch_wdata_i;
      end
    end
  end

  assign req_o   = req_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/llsc_seq.sv
module llsc_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ll_req_i,
  input  logic [AW-1:0] ll_addr_i,
  input  logic          sc_req_i,
  input  logic [AW-1:0] sc_addr_i,
  input  logic [DW-1:0] sc_data_i,
  input  logic          resv_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          arm_o,
  output logic          consume_o,
  output logic          launch_o,
  output logic          launch_we_o,
  output logic [AW-1:0] launch_addr_o,
  output logic [DW-1:0] launch_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          t_o,
  output logic [DW-1:0] r0_o
);
  import llsc_pkg::*;

  seq_state_e    state_q, state_d;
  logic          idle;
  logic          take_ll, take_sc, sc_pass;
  logic          done_q, t_q;
  logic [DW-1:0] r0_q;

  assign idle    = (state_q == ST_IDLE);
  assign take_ll = idle && ll_req_i;
  assign take_sc = idle && sc_req_i && !ll_req_i;
  assign sc_pass = take_sc && resv_i;

  assign arm_o          = take_ll;
  assign consume_o      = take_sc;
  assign launch_o       = take_ll || sc_pass;
  assign launch_we_o    = !take_ll;
  assign launch_addr_o  = take_ll ? ll_addr_i : sc_addr_i;
  assign launch_wdata_o = sc_data_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_ll)      state_d = ST_LOAD;
        else if (sc_pass) state_d = ST_STORE;
      end
      ST_LOAD, ST_STORE: if (mem_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      t_q     <= 1'b0;
      r0_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= (take_sc && !resv_i) || (!idle && mem_ack_i);
      if (take_sc) t_q <= resv_i;
      if (state_q == ST_LOAD && mem_ack_i) r0_q <= mem_rdata_i;
    end
  end

  assign busy_o = !idle;
  assign done_o = done_q;
  assign t_o    = t_q;
  assign r0_o   = r0_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ll_req_i,
  input  logic [AW-1:0] ll_addr_i,
  input  logic          sc_req_i,
  input  logic [AW-1:0] sc_addr_i,
  input  logic [DW-1:0] sc_data_i,
  input  logic          evt_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          t_o,
  output logic [DW-1:0] r0_o
);
  logic          resv_flag;
  logic          arm, consume, launch, launch_we;
  logic [AW-1:0] launch_addr;
  logic [DW-1:0] launch_wdata;

  llsc_resv_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .consume_i (consume),
    .evt_i     (evt_i),
    .flag_o    (resv_flag)
  );

  llsc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ll_req_i       (ll_req_i),
    .ll_addr_i      (ll_addr_i),
    .sc_req_i       (sc_req_i),
    .sc_addr_i      (sc_addr_i),
    .sc_data_i      (sc_data_i),
    .resv_i         (resv_flag),
    .mem_ack_i      (mem_ack_i),
    .mem_rdata_i    (mem_rdata_i),
    .arm_o          (arm),
    .consume_o      (consume),
    .launch_o       (launch),
    .launch_we_o    (launch_we),
    .launch_addr_o  (launch_addr),
    .launch_wdata_o (launch_wdata),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .t_o            (t_o),
    .r0_o           (r0_o)
  );

  llsc_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .launch_i       (launch),
    .launch_we_i    (launch_we),
    .launch_addr_i  (launch_addr),
    .launch_wdata_i (launch_wdata),
    .req_o          (mem_req_o),
    .we_o           (mem_we_o),
    .addr_o         (mem_addr_o),
    .wdata_o        (mem_wdata_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sc_req_i,
  input logic          evt_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          busy_o,
  input logic          t_o,
  input logic          resv_i
);
  // R8
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R8
  fields_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_ack_i) |=> (busy_o && $stable(mem_addr_o) &&
                                $stable(mem_wdata_o) && $stable(mem_we_o)));

  // R4
  write_needs_t_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> t_o);

  // R5
  store_clears_resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !resv_i);

  // R6 R7
  evt_clears_resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !resv_i);

  // R9
  busy_blocks_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sc_req_i) |=> !mem_req_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sc_req_i    (sc_req_i),
  .evt_i       (evt_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .t_o         (t_o),
  .resv_i      (resv_flag)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ll_req_i = 1'b0;
  logic [AW-1:0] ll_addr_i = '0;
  logic          sc_req_i = 1'b0;
  logic [AW-1:0] sc_addr_i = '0;
  logic [DW-1:0] sc_data_i = '0;
  logic          evt_i = 1'b0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ack_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          busy_o, done_o, t_o;
  logic [DW-1:0] r0_o;

  int tests = 0;
  int fails = 0;
  int wr_cnt = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  bit ref_resv = 1'b0;
  bit pend = 1'b0;
  int wait_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  llsc_monitor #(.AW(AW), .DW(DW)) u_dut (.*);

  function automatic logic [DW-1:0] rd_word(logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C96_0F5A;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // memory model: ack after 0..3 cycles, records writes
  initial forever begin
    @(negedge clk_i);
    mem_ack_i = 1'b0;
    if (mem_req_o) begin
      wait_cnt = $urandom_range(0, 3);
      pend = 1'b1;
    end
    if (pend) begin
      if (wait_cnt == 0) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = rd_word(mem_addr_o);
        if (mem_we_o) begin
          wr_cnt++;
          wr_addr = mem_addr_o;
          wr_data = mem_wdata_o;
        end
        pend = 1'b0;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic wait_done(string tag);
    int n = 0;
    while (!done_o && n < 64) begin
      @(negedge clk_i);
      n++;
    end
    chk(tag, {63'd0, done_o}, 64'd1);
  endtask

  // mode 0 plain, 1 evt at accept, 2 evt next cycle, 3 store while busy, 4 both strobes
  task automatic do_ll(logic [AW-1:0] a, int mode);
    int w0 = wr_cnt;
    @(negedge clk_i);
    ll_req_i = 1'b1; ll_addr_i = a;
    evt_i = (mode == 1);
    if (mode == 4) begin sc_req_i = 1'b1; sc_addr_i = a + 4; sc_data_i = ~a; end
    @(negedge clk_i);
    ll_req_i = 1'b0; sc_req_i = 1'b0;
    evt_i = (mode == 2);
    if (mode == 3) begin sc_req_i = 1'b1; sc_addr_i = a ^ 32'hFF; sc_data_i = a; end
    @(negedge clk_i);
    evt_i = 1'b0; sc_req_i = 1'b0;
    wait_done("R2 load done");
    chk("R2 load data", {32'd0, r0_o}, {32'd0, rd_word(a)});
    chk("R9 no write during load", wr_cnt, w0);
    ref_resv = (mode == 0 || mode >= 3);
  endtask

  task automatic do_sc(logic [AW-1:0] a, logic [DW-1:0] d, bit evt_same);
    int w0 = wr_cnt;
    bit exp_t = ref_resv;
    @(negedge clk_i);
    sc_req_i = 1'b1; sc_addr_i = a; sc_data_i = d; evt_i = evt_same;
    @(negedge clk_i);
    sc_req_i = 1'b0; evt_i = 1'b0;
    wait_done("R4 store done");
    chk("R3 t copy", {63'd0, t_o}, {63'd0, exp_t});
    if (exp_t) begin
      chk("R4 one write", wr_cnt, w0 + 1);
      chk("R4 write addr", {32'd0, wr_addr}, {32'd0, a});
      chk("R4 write data", {32'd0, wr_data}, {32'd0, d});
    end else begin
      chk("R4 no write on fail", wr_cnt, w0);
    end
    ref_resv = 1'b0;
  endtask

  task automatic do_evt();
    @(negedge clk_i); evt_i = 1'b1;
    @(negedge clk_i); evt_i = 1'b0;
    ref_resv = 1'b0;
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_tb();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 req", {63'd0, mem_req_o}, 64'd0);
    chk("R1 busy", {63'd0, busy_o}, 64'd0);
    chk("R1 done", {63'd0, done_o}, 64'd0);
    chk("R1 t", {63'd0, t_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_sc(32'h0000_1000, 32'hDEAD_BEEF, 1'b0);  // R1 first store fails

    // R2/R3/R4/R5 success then failure
    do_ll(32'h8000_0010, 0);
    do_sc(32'h8000_0010, 32'h1234_5678, 1'b0);
    do_sc(32'h8000_0010, 32'h0BAD_F00D, 1'b0);  // R5
    // R6 evt alone, and during load wait
    do_ll(32'h0000_0044, 0);
    do_evt();
    do_sc(32'h0000_0044, 32'h1, 1'b0);
    do_ll(32'h0000_0048, 2);
    do_sc(32'h0000_0048, 32'h2, 1'b0);
    // R7 evt at load acceptance
    do_ll(32'hFFFF_FFFC, 1);
    do_sc(32'hFFFF_FFFC, 32'h3, 1'b0);
    // R10 evt at store acceptance
    do_ll(32'h0000_0100, 0);
    do_sc(32'h0000_0100, 32'hCAFE_0001, 1'b1);
    do_sc(32'h0000_0100, 32'hCAFE_0002, 1'b0);
    // R9 store while busy ignored; both strobes: load wins
    do_ll(32'h0000_0200, 3);
    do_sc(32'h0000_0204, 32'hA5A5_0003, 1'b0);
    do_ll(32'h0000_0300, 4);
    do_sc(32'h0000_0304, 32'hA5A5_0004, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4)       do_ll($urandom, $urandom_range(0, 4));
      else if (op < 9)  do_sc($urandom, $urandom, ($urandom_range(0, 7) == 0));
      else              do_evt();
    end
    finish_tb();
  end
endmodule